// File: doc/BRIEF.md
# Multi-Context Reservation Monitor

This block keeps one address reservation for each hardware thread context. Together these reservations support load-locked / store-conditional sequences in a small shared-memory system. Each cycle the block can take at most one memory request. A request carries a context id, a physical address, a read/write direction, a locked flag and an uncacheable flag. A locked read reserves a 16-byte aligned granule for the issuing context. A locked write is a store-conditional. The block judges it and tells memory whether the write may proceed. Every write that does proceed cancels all reservations that cover its granule, in every context.

The outputs are a 2-bit result code and a memory write-enable, both in the same cycle as the request. There is also a per-context warning pulse. It fires when a context's run of consecutive failed store-conditionals reaches a multiple of a configurable period, which defaults to 100000. The memory array, address translation and byte ordering are handled elsewhere.

Top module: `resv_monitor`

## Requirements
- R1: After reset no context holds a reservation and all failure runs are zero. A cacheable store-conditional from any context then returns code 0 with the write-enable low, and no warning is raised.
- R2: A valid read with the locked flag records the address granule for its context and marks the reservation live. A later cacheable store-conditional from that context to the same granule returns code 1 and raises the write-enable.
- R3: Reservations compare only address bits [ADDR_W-1:4]. A store-conditional at any byte offset inside the reserved 16-byte granule matches, and one in another granule does not.
- R4: A cacheable store-conditional returns code 1 whenever its context's reservation is live, and code 0 otherwise, even when the granule differs. The write-enable is high only when the reservation is live and the granule matches.
- R5: A failing cacheable store-conditional cancels the issuer's reservation, raises no write, and leaves every other context's reservation untouched.
- R6: A store-conditional with the uncacheable flag returns code 2 and raises the write-enable whatever the reservation state. It also restarts the issuer's failure run.
- R7: Every write that proceeds cancels the reservation of every context, the issuer included, whose recorded granule equals the write's granule. Such writes are plain stores, passing store-conditionals and uncacheable store-conditionals.
- R8: Each failing store-conditional lengthens the issuer's failure run, and a passing or uncacheable one restarts it at zero. When the run reaches a multiple of WARN_PERIOD, that context's warning bit is high for exactly the one cycle after the request.
- R9: Plain reads and locked reads return code 0 with the write-enable low. Plain stores return code 0 with the write-enable high.
- R10: While the valid input is low, the code is 0, the write-enable is low, and no reservation or failure run changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ctx | input | CTX_W | Issuing context id |
| req_addr | input | ADDR_W | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_locked | input | 1 | Locked read or store-conditional |
| req_uncache | input | 1 | Uncacheable access |
| sc_result | output | 2 | 0 = fail or not applicable, 1 = pass, 2 = uncacheable conditional |
| mem_wr_en | output | 1 | Write may proceed to memory |
| fail_warn | output | NUM_CTX | Per-context failure-run warning pulse |

## Verification
The result code and write-enable depend combinationally on the request and the current reservations. The bench samples them two nanoseconds after driving the request, well before the capturing edge. Reservation and failure-run updates take effect at that edge, so the next request sees them. The warning is a registered output due one cycle after the failing request. It is compared two nanoseconds after the edge that follows the request, against a reference model that keeps unbounded failure counts and tests them for divisibility by the period.

// File: rtl/resv_monitor_pkg.sv
package resv_monitor_pkg;

    typedef enum logic [1:0] {
        SC_NONE     = 2'd0,
        SC_PASS     = 2'd1,
        SC_UNCACHED = 2'd2
    } sc_code_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_LOCK_READ,
        OP_STORE,
        OP_COND_STORE,
        OP_COND_UNCACHED
    } op_kind_e;

    // Decision produced for one request
    typedef struct packed {
        sc_code_e code;
        logic     wr_en;
        logic     reserve;   // record a reservation for the issuer
        logic     drop_own;  // cancel the issuer's reservation only
        logic     sweep;     // cancel all reservations on the granule
        logic     fail_evt;  // lengthen issuer's failure run
        logic     clr_evt;   // restart issuer's failure run
    } verdict_t;

    function automatic op_kind_e classify(input logic valid, input logic write,
                                          input logic locked, input logic uncache);
        op_kind_e k;
        if (!valid)
            k = OP_IDLE;
        else if (!write)
            k = locked ? OP_LOCK_READ : OP_READ;
        else if (!locked)
            k = OP_STORE;
        else
            k = uncache ? OP_COND_UNCACHED : OP_COND_STORE;
        return k;
    endfunction

endpackage

// File: rtl/resv_table.sv
module resv_table #(
    parameter int NUM_CTX = 4,
    parameter int GW      = 28,
    parameter int CTX_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        set_en,
    input  logic [CTX_W-1:0]            set_ctx,
    input  logic [GW-1:0]               set_gran,
    input  logic                        drop_en,
    input  logic [CTX_W-1:0]            drop_ctx,
    input  logic                        sweep_en,
    input  logic [GW-1:0]               sweep_gran,
    output logic [NUM_CTX-1:0]          live_o,
    output logic [NUM_CTX-1:0][GW-1:0]  gran_o
);

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        logic          live_q;
        logic [GW-1:0] gran_q;
        logic          mine_set;
        logic          mine_drop;
        logic          swept;

        assign mine_set  = set_en  && (set_ctx  == CTX_W'(i));
        assign mine_drop = drop_en && (drop_ctx == CTX_W'(i));
        assign swept     = sweep_en && (gran_q == sweep_gran);

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q <= 1'b0;
                gran_q <= '0;
            end else if (mine_set) begin
                live_q <= 1'b1;
                gran_q <= set_gran;
            end else if (mine_drop || swept) begin
                live_q <= 1'b0;
            end
        end

        assign live_o[i] = live_q;
        assign gran_o[i] = gran_q;
    end

endmodule

// File: rtl/sc_judge.sv
module sc_judge #(
    parameter int GW = 28
) (
    input  resv_monitor_pkg::op_kind_e op,
    input  logic                       own_live,
    input  logic [GW-1:0]              own_gran,
    input  logic [GW-1:0]              req_gran,
    output resv_monitor_pkg::verdict_t verdict
);
    import resv_monitor_pkg::*;

    logic hit;
    assign hit = own_live && (own_gran == req_gran);

    always_comb begin
        verdict = '0;
        verdict.code = SC_NONE;
        unique case (op)
            OP_LOCK_READ: verdict.reserve = 1'b1;
            OP_STORE: begin
                verdict.wr_en = 1'b1;
                verdict.sweep = 1'b1;
            end
            OP_COND_STORE: begin
                // code mirrors the live bit, even on a granule mismatch
                verdict.code = own_live ? SC_PASS : SC_NONE;
                if (hit) begin
                    verdict.wr_en   = 1'b1;
                    verdict.sweep   = 1'b1;
                    verdict.clr_evt = 1'b1;
                end else begin
                    verdict.drop_own = 1'b1;
                    verdict.fail_evt = 1'b1;
                end
            end
            OP_COND_UNCACHED: begin
                verdict.code    = SC_UNCACHED;
                verdict.wr_en   = 1'b1;
                verdict.sweep   = 1'b1;
                verdict.clr_evt = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fail_tracker.sv
module fail_tracker #(
    parameter int NUM_CTX     = 4,
    parameter int CTX_W       = 2,
    parameter int WARN_PERIOD = 100000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fail_en,
    input  logic               clr_en,
    input  logic [CTX_W-1:0]   ctx,
    output logic [NUM_CTX-1:0] warn_o
);
    localparam int CNT_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WARN_PERIOD - 1);

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_run
        logic [CNT_W-1:0] phase_q;
        logic             warn_q;
        logic             sel;

        assign sel = (ctx == CTX_W'(i));

        // phase_q holds the run length modulo WARN_PERIOD
        always_ff @(posedge clk) begin
            if (rst) begin
                phase_q <= '0;
                warn_q  <= 1'b0;
            end else begin
                warn_q <= 1'b0;
                if (sel && clr_en) begin
                    phase_q <= '0;
                end else if (sel && fail_en) begin
                    if (phase_q == LAST) begin
                        phase_q <= '0;
                        warn_q  <= 1'b1;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
            end
        end

        assign warn_o[i] = warn_q;
    end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int NUM_CTX     = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int WARN_PERIOD = 100000,
    localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic               req_locked,
    input  logic               req_uncache,
    output logic [1:0]         sc_result,
    output logic               mem_wr_en,
    output logic [NUM_CTX-1:0] fail_warn
);
    import resv_monitor_pkg::*;

    localparam int GW = ADDR_W - GRAN_BITS;

    op_kind_e                  op;
    verdict_t                  verdict;
    logic [GW-1:0]             req_gran;
    logic [NUM_CTX-1:0]        live;
    logic [NUM_CTX-1:0][GW-1:0] gran;
    logic                      own_live;
    logic [GW-1:0]             own_gran;

    assign op       = classify(req_valid, req_write, req_locked, req_uncache);
    assign req_gran = req_addr[ADDR_W-1:GRAN_BITS];
    assign own_live = live[req_ctx];
    assign own_gran = gran[req_ctx];

    sc_judge #(.GW(GW)) u_judge (
        .op       (op),
        .own_live (own_live),
        .own_gran (own_gran),
        .req_gran (req_gran),
        .verdict  (verdict)
    );

    resv_table #(.NUM_CTX(NUM_CTX), .GW(GW), .CTX_W(CTX_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .set_en     (verdict.reserve),
        .set_ctx    (req_ctx),
        .set_gran   (req_gran),
        .drop_en    (verdict.drop_own),
        .drop_ctx   (req_ctx),
        .sweep_en   (verdict.sweep),
        .sweep_gran (req_gran),
        .live_o     (live),
        .gran_o     (gran)
    );

    fail_tracker #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .WARN_PERIOD(WARN_PERIOD)) u_fail (
        .clk     (clk),
        .rst     (rst),
        .fail_en (verdict.fail_evt),
        .clr_en  (verdict.clr_evt),
        .ctx     (req_ctx),
        .warn_o  (fail_warn)
    );

    assign sc_result = verdict.code;
    assign mem_wr_en = verdict.wr_en;

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [CTX_W-1:0]   req_ctx,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_write,
    input logic               req_locked,
    input logic               req_uncache,
    input logic [1:0]         sc_result,
    input logic               mem_wr_en,
    input logic [NUM_CTX-1:0] fail_warn
);
    logic cond_cached;
    assign cond_cached = req_valid && req_write && req_locked && !req_uncache;

    // R6
    uc_code_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_locked && req_uncache) |-> (sc_result == 2'd2 && mem_wr_en));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (sc_result == 2'd0 && !mem_wr_en));

    // R9
    read_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |-> (sc_result == 2'd0 && !mem_wr_en));

    // R4
    sc_write_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_cached && mem_wr_en) |-> (sc_result == 2'd1));

    // R8
    warn_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fail_warn));

    // R8
    warn_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|fail_warn) |-> $past(cond_cached && !mem_wr_en));

    logic unused_ok;
    assign unused_ok = ^{req_ctx, req_addr};

endmodule

bind resv_monitor resv_monitor_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx), .req_addr(req_addr),
    .req_write(req_write), .req_locked(req_locked), .req_uncache(req_uncache),
    .sc_result(sc_result), .mem_wr_en(mem_wr_en), .fail_warn(fail_warn)
);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
    localparam int NC = 4;
    localparam int AW = 12;
    localparam int PER = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_locked = 1'b0;
    logic          req_uncache = 1'b0;
    logic [1:0]    sc_result;
    logic          mem_wr_en;
    logic [NC-1:0] fail_warn;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    bit m_live [NC];
    int m_gran [NC];
    int m_run  [NC];

    always #10 clk = ~clk;

    resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(PER)) u_resv_monitor (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx), .req_addr(req_addr),
        .req_write(req_write), .req_locked(req_locked), .req_uncache(req_uncache),
        .sc_result(sc_result), .mem_wr_en(mem_wr_en), .fail_warn(fail_warn)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sweep_model(input int g);
        for (int k = 0; k < NC; k++)
            if (m_gran[k] == g) m_live[k] = 0;
    endtask

    task automatic step(input bit v, input int c, input int a, input bit w,
                        input bit lk, input bit uc, input string tg);
        int g, eres, ewr, ewarn;
        string t;
        @(negedge clk);
        req_valid = v; req_ctx = 2'(c); req_addr = AW'(a);
        req_write = w; req_locked = lk; req_uncache = uc;
        #2;
        g = a >> 4; eres = 0; ewr = 0; ewarn = 0;
        if (!v) t = "R10";
        else if (!w) begin
            t = lk ? "R2" : "R9";
            if (lk) begin m_live[c] = 1; m_gran[c] = g; end
        end else if (!lk) begin
            t = "R7"; ewr = 1; sweep_model(g);
        end else if (uc) begin
            t = "R6"; eres = 2; ewr = 1; m_run[c] = 0; sweep_model(g);
        end else begin
            t = "R4"; eres = m_live[c] ? 1 : 0;
            if (m_live[c] && m_gran[c] == g) begin
                ewr = 1; m_run[c] = 0; sweep_model(g);
            end else begin
                m_live[c] = 0; m_run[c]++;
                if (m_run[c] % PER == 0) ewarn = 1 << c;
            end
        end
        if (tg != "") t = tg;
        check(sc_result == 2'(eres), {t, " code"}, int'(sc_result), eres);
        check(mem_wr_en == ewr[0], {t, " wr_en"}, int'(mem_wr_en), ewr);
        @(posedge clk);
        #2;
        check(fail_warn == NC'(ewarn), "R8 warn", int'(fail_warn), ewarn);
    endtask

    initial begin
        for (int k = 0; k < NC; k++) begin m_live[k] = 0; m_gran[k] = 0; m_run[k] = 0; end
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check(fail_warn == '0, "R1 warn after reset", int'(fail_warn), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NC; c++) step(1, c, 16 * c, 1, 1, 0, "R1");
        // R2 / R3: reserve, then pass at another byte offset in the granule
        step(1, 0, 'h040, 0, 1, 0, "R2");
        step(1, 0, 'h04C, 1, 1, 0, "R3");
        // R3 / R4: live reservation, different granule -> code 1, no write
        step(1, 1, 'h080, 0, 1, 0, "R2");
        step(1, 1, 'h090, 1, 1, 0, "R3");
        step(1, 1, 'h080, 1, 1, 0, "R4");
        // R5: failing conditional leaves another context alone
        step(1, 2, 'h100, 0, 1, 0, "R2");
        step(1, 3, 'h108, 0, 1, 0, "R2");
        step(1, 2, 'h200, 1, 1, 0, "R5");
        step(1, 3, 'h104, 1, 1, 0, "R5");
        // R7: plain store cancels every matching reservation
        step(1, 0, 'h300, 0, 1, 0, "R2");
        step(1, 1, 'h30F, 0, 1, 0, "R2");
        step(1, 2, 'h30C, 1, 0, 0, "R7");
        step(1, 0, 'h300, 1, 1, 0, "R7");
        step(1, 1, 'h300, 1, 1, 0, "R7");
        // R6: uncacheable conditional, no reservation
        step(1, 1, 'h500, 1, 1, 1, "R6");
        // R10: idle with busy-looking inputs
        step(1, 2, 'h600, 0, 1, 0, "R2");
        step(0, 2, 'h600, 1, 0, 0, "R10");
        step(1, 2, 'h600, 1, 1, 0, "R10");
        // R9: plain read
        step(1, 3, 'h700, 0, 0, 0, "R9");
        // R8: long failure run, then restart by uncacheable conditional
        for (int i = 0; i < 7; i++) step(1, 3, 'h7F0, 1, 1, 0, "");
        step(1, 3, 'h7F0, 1, 1, 1, "R6");
        for (int i = 0; i < 3; i++) step(1, 3, 'h7F0, 1, 1, 0, "");
        // sweep over a few granules and all kinds of request
        for (int i = 0; i < 3000; i++) begin
            int kind, c, a;
            kind = $urandom % 6;
            c = $urandom % NC;
            a = (($urandom % 4) << 4) | ($urandom % 16);
            case (kind)
                0: step(0, c, a, 0, 0, 0, "");
                1: step(1, c, a, 0, 0, 0, "");
                2: step(1, c, a, 0, 1, 0, "");
                3: step(1, c, a, 1, 0, 0, "");
                4: step(1, c, a, 1, 1, 0, "");
                default: step(1, c, a, 1, 1, ($urandom % 4) == 0, "");
            endcase
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule